// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit watches 128 general-purpose inputs, grouped as four banks of 32 pins. Each pin is first passed through a two-flop synchroniser. Software then picks, per pin, whether a rising transition, a falling transition, both, or neither is recorded. A recorded transition sets a sticky status bit. That bit stays set until software clears it by writing a one to it.

Pins 0 and 1 each have their own interrupt line. Every pin from 2 upward feeds one shared interrupt line. All three lines are level signals. A typical handler reads a status register and writes the same value back, which clears exactly the events it has just seen. Any transition that arrives in the meantime is kept.

Register access is a single-cycle bus. A write is committed on the rising clock edge while `bus_we` is high. A read is combinational from `bus_addr`.

Top module: `gpio_edge_irq`

## Requirements
- R1: `bus_addr[3:2]` selects the bank, which covers pins 32*bank to 32*bank+31, with bit n holding pin 32*bank+n. `bus_addr[1:0]` selects the register within the bank: 0 is the rising enable, 1 is the falling enable, 2 is the status register, and 3 reads as zero and ignores writes.
- R2: A rising transition on a pin sets its status bit only when its rising-enable bit is 1.
- R3: A falling transition sets the status bit only when the falling-enable bit is 1. With both enables set, either transition sets the bit. With neither set, the pin never flags.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged.
- R5: A transition detected in the same cycle as a clearing write to that bit wins, so the bit stays 1.
- R6: `irq_pin0` and `irq_pin1` are high exactly while the status bits of pins 0 and 1 are set.
- R7: `irq_shared` is high while any status bit of pins 2 to 127 is set. Pins 0 and 1 do not drive it.
- R8: After reset, all enable registers and status bits read 0, and all three interrupt outputs are low.
- R9: Clearing an enable bit does not clear a status bit that is already set.
- R10: Suppose a pin changes just before rising edge k. Its status bit is still 0 after edge k+1 and reads 1 after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_in | input | 128 | Asynchronous GPIO input levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Bank in bits 3:2, register select in bits 1:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_pin0 | output | 1 | Level interrupt for pin 0 |
| irq_pin1 | output | 1 | Level interrupt for pin 1 |
| irq_shared | output | 1 | Level interrupt for pins 2 to 127 |

## Verification
A vector table covers every pairing of enable setting with transition direction, spread across all four banks and including the top and bottom bit of a bank. This separates a pin that flags only on its programmed direction from one that flags on any change or on the wrong bank. Directed sequences cover the remaining cases:
- They time a clearing write to land in the very cycle a second transition is detected, which tells edge-over-clear priority apart from clear-over-edge.
- They count cycles from a pin change to the status bit, which pins down the synchroniser depth.
- They drive pin 0 alone, which shows that the dedicated lines are kept apart from the shared one.

// File: rtl/gei_pkg.sv
// Shared constants and register-select encoding for the GPIO edge interrupt unit.
// Assumes a 2-bit select field in the low bits of the register address.
package gei_pkg;
    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_RISE_EN = 2'd0,
        SEL_FALL_EN = 2'd1,
        SEL_STATUS  = 2'd2,
        SEL_UNUSED  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gei_sync.sv
// Two-flop synchroniser with a one-cycle history register per pin.
// Assumes the inputs are asynchronous and that one extra flop of history is
// enough to compare the current and previous synchronised levels.
module gei_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] level_now,
    output logic [WIDTH-1:0] level_prev
);
    logic [WIDTH-1:0] meta_q;

    // Capture the raw inputs through two flops, then keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q     <= '0;
            level_now  <= '0;
            level_prev <= '0;
        end else begin
            meta_q     <= raw_in;
            level_now  <= meta_q;
            level_prev <= level_now;
        end
    end
endmodule

// File: rtl/gei_bank.sv
// One bank of pins: rising and falling enables, edge qualification and a
// sticky write-one-to-clear status register. In the same cycle a detected
// edge takes priority over a clear of that bit.
// Assumes the synchronised level and its one-cycle history come from gei_sync.
module gei_bank
    import gei_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_now,
    input  logic [WIDTH-1:0] level_prev,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] status
);
    logic [WIDTH-1:0] rise_en_q;
    logic [WIDTH-1:0] fall_en_q;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] clr_mask;

    // Qualify each pin's transitions against its two enables.
    always_comb begin
        hit = (level_now & ~level_prev & rise_en_q) |
              (~level_now & level_prev & fall_en_q);
    end

    // Bits that a status write asks to clear this cycle.
    always_comb begin
        clr_mask = (wr_en && sel == SEL_STATUS) ? wr_data : '0;
    end

    // Update the enable registers from bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_RISE_EN) rise_en_q <= wr_data;
            if (sel == SEL_FALL_EN) fall_en_q <= wr_data;
        end
    end

    // Sticky status: clear on write-one, set on a qualified edge, edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | hit;
    end

    // Read multiplexer for this bank.
    always_comb begin
        unique case (sel)
            SEL_RISE_EN: rd_data = rise_en_q;
            SEL_FALL_EN: rd_data = fall_en_q;
            SEL_STATUS:  rd_data = status;
            default:     rd_data = '0;
        endcase
    end

    // R4: bits written with 1 and not hit by an edge read 0 afterwards.
    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_STATUS) |=> ((status & $past(wr_data) & ~$past(hit)) == '0));

    // R2/R3: a status bit only rises when a qualified edge was seen.
    assert_set_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(hit)) == '0));

    // R9: without a status write, set bits never drop (enable changes included).
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_STATUS) |=> ((~status & $past(status)) == '0));

    // R5: an edge in the same cycle as a clear leaves the bit set.
    assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hit) & ~status) == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
// Top of the GPIO edge-detect interrupt unit: NUM_BANKS banks of BANK_W pins,
// a register bus decode, and three level interrupts (pin 0, pin 1, all others).
// Assumes a single clock domain for the bus and synchronous active-low reset.
module gpio_edge_irq
    import gei_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned BANK_W    = 32,
    localparam int unsigned PINS     = NUM_BANKS * BANK_W,
    localparam int unsigned BANK_AW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned ADDR_W   = BANK_AW + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pins_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              irq_pin0,
    output logic              irq_pin1,
    output logic              irq_shared
);
    logic [PINS-1:0]   lvl_now;
    logic [PINS-1:0]   lvl_prev;
    logic [BANK_W-1:0] bank_rd   [NUM_BANKS];
    logic [BANK_W-1:0] bank_stat [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_any;
    logic [BANK_AW-1:0] bank_idx;
    reg_sel_e           sel;

    // Split the address into bank index and register select.
    always_comb begin
        bank_idx = bus_addr[ADDR_W-1:SEL_W];
        sel      = reg_sel_e'(bus_addr[SEL_W-1:0]);
    end

    gei_sync #(.WIDTH(PINS)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (pins_in),
        .level_now  (lvl_now),
        .level_prev (lvl_prev)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_this;

        // Route the write strobe to the addressed bank only.
        always_comb wr_this = bus_we && (bank_idx == BANK_AW'(b));

        gei_bank #(.WIDTH(BANK_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_now  (lvl_now[b*BANK_W +: BANK_W]),
            .level_prev (lvl_prev[b*BANK_W +: BANK_W]),
            .wr_en      (wr_this),
            .sel        (sel),
            .wr_data    (bus_wdata),
            .rd_data    (bank_rd[b]),
            .status     (bank_stat[b])
        );

        // Per-bank contribution to the shared line; pins 0 and 1 are excluded.
        if (b == 0) begin : g_low
            always_comb bank_any[b] = |bank_stat[b][BANK_W-1:2];
        end else begin : g_high
            always_comb bank_any[b] = |bank_stat[b];
        end
    end

    // Select the read data of the addressed bank.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_idx == BANK_AW'(i)) bus_rdata = bank_rd[i];
        end
    end

    // Drive the three level interrupt outputs.
    always_comb begin
        irq_pin0   = bank_stat[0][0];
        irq_pin1   = bank_stat[0][1];
        irq_shared = |bank_any;
    end

    // R8: one cycle after reset is applied, all interrupt lines are low.
    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> !(irq_pin0 || irq_pin1 || irq_shared));
endmodule

// File: tb/gpio_edge_irq_tb.sv
// Self-checking bench: a table of single-pin edge cases, then directed tests.
module gpio_edge_irq_tb;
    localparam int unsigned PINS = 128;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [127:0] pins_in;
    logic         bus_we;
    logic [3:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic         irq_pin0, irq_pin1, irq_shared;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_edge_irq u_dut (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared)
    );

    // Vector: {bank[1:0], bit[4:0], rise_en, fall_en, rising, expect}
    localparam logic [10:0] VEC [8] = '{
        {2'd0, 5'd5,  1'b1, 1'b0, 1'b1, 1'b1},
        {2'd1, 5'd7,  1'b1, 1'b0, 1'b0, 1'b0},
        {2'd2, 5'd31, 1'b0, 1'b1, 1'b0, 1'b1},
        {2'd3, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0},
        {2'd1, 5'd15, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd3, 5'd20, 1'b1, 1'b1, 1'b0, 1'b1},
        {2'd2, 5'd3,  1'b0, 1'b0, 1'b1, 1'b0},
        {2'd0, 5'd2,  1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_pin(input int idx, input logic v);
        @(negedge clk);
        pins_in[idx] = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; pins_in = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state of all registers and outputs.
        for (int b = 0; b < 4; b++) begin
            for (int s = 0; s < 3; s++) begin
                bus_read(4'(b * 4 + s), rd);
                check("R8 reset register", rd, 32'h0);
            end
        end
        check("R8 reset irqs", {29'd0, irq_pin0, irq_pin1, irq_shared}, 32'h0);

        // R1: register 3 reads zero even after a write.
        bus_write(4'd3, 32'hFFFF_FFFF);
        bus_read(4'd3, rd);
        check("R1 unused select", rd, 32'h0);

        // Table walk: R1 R2 R3 R7.
        for (int v = 0; v < 8; v++) begin
            logic [1:0] bk; logic [4:0] bt; logic re, fe, up, ex; int idx;
            {bk, bt, re, fe, up, ex} = VEC[v];
            idx = int'(bk) * 32 + int'(bt);
            if (!up) set_pin(idx, 1'b1);
            bus_write({bk, 2'd2}, 32'hFFFF_FFFF);
            bus_write({bk, 2'd0}, re ? (32'd1 << bt) : 32'd0);
            bus_write({bk, 2'd1}, fe ? (32'd1 << bt) : 32'd0);
            set_pin(idx, up);
            bus_read({bk, 2'd2}, rd);
            check(up ? "R2 rising vector" : "R3 falling vector", rd, ex ? (32'd1 << bt) : 32'd0);
            check("R7 shared line", {31'd0, irq_shared}, {31'd0, ex});
            bus_write({bk, 2'd0}, 32'd0);
            bus_write({bk, 2'd1}, 32'd0);
            set_pin(idx, 1'b0);
            bus_write({bk, 2'd2}, 32'hFFFF_FFFF);
            check("R4 cleanup clear", {31'd0, irq_shared}, 32'd0);
        end

        // R6 and R10: pin 0 rising with latency count.
        bus_write(4'd0, 32'h1);
        @(negedge clk); pins_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 not yet set", {31'd0, irq_pin0}, 32'd0);
        @(negedge clk);
        check("R10 set after third edge", {31'd0, irq_pin0}, 32'd1);
        check("R6 dedicated lines", {29'd0, irq_pin0, irq_pin1, irq_shared}, 32'b100);

        // R4: writing 0 leaves the bit set.
        bus_write(4'd2, 32'h0);
        bus_read(4'd2, rd);
        check("R4 write zero keeps", rd, 32'h1);

        // R9: disabling the enable keeps status.
        bus_write(4'd0, 32'h0);
        bus_read(4'd2, rd);
        check("R9 enable off keeps status", rd, 32'h1);

        // R4: write one clears and drops the line.
        bus_write(4'd2, 32'h1);
        bus_read(4'd2, rd);
        check("R4 write one clears", rd, 32'h0);
        check("R6 line drops", {31'd0, irq_pin0}, 32'd0);

        // R5: pin 1 falling edge detected in the same cycle as a clear.
        bus_write(4'd1, 32'h2);
        bus_write(4'd0, 32'h2);
        set_pin(1, 1'b1);
        check("R6 pin1 line", {30'd0, irq_pin1, irq_pin0}, 32'b10);
        @(negedge clk); pins_in[1] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 4'd2; bus_wdata = 32'h2; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        bus_read(4'd2, rd);
        check("R5 edge beats clear", rd, 32'h2);
        bus_write(4'd2, 32'h2);
        bus_read(4'd2, rd);
        check("R5 later clear works", rd, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule